// File: doc/BRIEF.md
# Debug Line Sync Pulse Width Meter

This block finds out how fast a target's single-wire debug clock runs. When started, it drives the bidirectional debug line high for a few host cycles and then low for a programmable request period. That period is chosen to be longer than any normal bit cell. It then drives the line high again for a few cycles and releases it. After that, the target answers with a low pulse that lasts a fixed number of its own clock cycles.

A free-running counter on the host clock is captured when the reply's falling edge arrives and again when its rising edge arrives. The reported result is the second capture minus the first, so it is the reply's length in host cycles. Software or a neighbouring block can then scale that figure to set bit timing.

Each of the two edge waits has its own timeout counter, loaded from a programmable value. If either edge fails to arrive in time, the block reports zero. The line input passes through a synchroniser. Because both edges see the same synchroniser delay, that delay cancels out of the result.

Top module: `sync_width_meter`

## Requirements
- R1: After reset the line is released (output enable 0), the done flag is 0 and the result is 0.
- R2: A start strobe in idle makes the block drive the line high for HIGH_CYC cycles before the request and again for HIGH_CYC cycles after it. It then releases the line. A release always follows a cycle in which the line was driven high.
- R3: The request drives the line low for exactly req_len_i host cycles. A req_len_i of 0 is treated as 1.
- R4: The falling edge is captured first, and only then is the rising edge awaited. The result is the rising-edge count minus the falling-edge count, modulo 2^16. This equals the reply's low time in host cycles.
- R5: done_o is a single-cycle pulse. For a good reply it rises 3 host cycles after the line returns high. The result stays unchanged until the next done pulse.
- R6: If no falling edge is seen, done_o pulses with a result of 0 exactly timeout_i+1 cycles after the line is released.
- R7: If the rising edge does not follow within timeout_i cycles of the falling edge, done_o pulses with a result of 0.
- R8: A start strobe that arrives while a measurement is running is ignored. The line stays released, and exactly one done pulse ends the running measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; also clocks the capture counter |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that begins a measurement |
| req_len_i | input | LEN_W | Low request length in host cycles |
| timeout_i | input | TMO_W | Per-edge wait limit in host cycles |
| line_in_i | input | 1 | Sampled level of the debug line |
| line_oe_o | output | 1 | 1 = drive the debug line, 0 = release it |
| line_out_o | output | 1 | Level driven while line_oe_o is 1 |
| width_o | output | CNT_W | Measured low time of the reply, 0 on timeout |
| done_o | output | 1 | One-cycle pulse when width_o is updated |

## Verification
The drive phases are checked cycle by cycle. The bench samples the line enable and level at every falling clock edge from the cycle after the start strobe, and counts the high, low and high phases against HIGH_CYC and req_len_i. For a good reply, the done pulse is due three cycles after the bench's model target lets the line go high: two synchroniser stages plus the result register. For a missing falling edge, it is due timeout_i+1 cycles after release. The bench records the cycle number of each event at falling edges and compares the differences exactly. The pulse count and the held result are read four cycles later.

// File: rtl/swm_pkg.sv
// Shared types for the sync pulse width meter.
// Assumes: nothing beyond IEEE 1800-2017.
package swm_pkg;

    // Sequencer phases: drive high, drive low request, drive high, wait falling, wait rising.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_REQ   = 3'd2,
        ST_POST  = 3'd3,
        ST_WFALL = 3'd4,
        ST_WRISE = 3'd5
    } swm_state_e;

endpackage

// File: rtl/swm_edge_sync.sv
// Synchroniser and edge detector for the debug line input.
// Assumes: STAGES >= 2, line idles high, so the flops reset to 1.
module swm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o,
    output logic rise_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;
    logic         prev_q;

    // Shift the raw line level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[TOP-1:0], line_i};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[TOP];
    end

    assign fall_o = prev_q & ~chain_q[TOP];
    assign rise_o = ~prev_q & chain_q[TOP];
endmodule

// File: rtl/swm_stamp.sv
// Free-running time stamp counter on the host clock; wraps modulo 2^W.
// Assumes: nothing; it never stops.
module swm_stamp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] stamp_o
);
    logic [W-1:0] cnt_q;

    // Advance the stamp every host cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + W'(1);
    end

    assign stamp_o = cnt_q;
endmodule

// File: rtl/swm_down_timer.sv
// Loadable down counter that stops at zero and flags it.
// Assumes: load takes priority over run.
module swm_down_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         run_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load a new count or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load_i)               cnt_q <= val_i;
        else if (run_i && cnt_q != '0) cnt_q <= cnt_q - W'(1);
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/swm_seq.sv
// Measurement sequencer: drives the request, then captures the reply's edges
// and forms the width. Each edge wait has its own timeout timer.
// Assumes: fall_i/rise_i are single-cycle pulses from a synchronised line,
// HIGH_CYC >= 1 and fits in LEN_W bits.
module swm_seq
    import swm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int LEN_W    = 16,
    parameter int TMO_W    = 16,
    parameter int HIGH_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic [TMO_W-1:0] timeout_i,
    input  logic             fall_i,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] stamp_i,
    output logic             line_oe_o,
    output logic             line_out_o,
    output logic [CNT_W-1:0] width_o,
    output logic             done_o
);
    localparam logic [LEN_W-1:0] HI_LOAD = LEN_W'(HIGH_CYC - 1);
    localparam int NWAIT = 2;   // index 0: falling wait, 1: rising wait

    swm_state_e       state_q, state_d;
    logic [CNT_W-1:0] t_fall_q, width_q;
    logic             done_q;

    logic             ph_load, ph_zero, ph_run;
    logic [LEN_W-1:0] ph_val, req_m1;
    logic [NWAIT-1:0] w_load, w_run, w_zero;
    logic             cap_fall, fin_ok, fin_tmo;

    assign req_m1 = (req_len_i == '0) ? '0 : req_len_i - LEN_W'(1);

    // Phase length timer for the driven high, low and high periods.
    swm_down_timer #(.W(LEN_W)) i_phase (
        .clk(clk), .rst_n(rst_n), .load_i(ph_load), .val_i(ph_val),
        .run_i(ph_run), .zero_o(ph_zero)
    );

    // One timeout timer per edge wait.
    for (genvar g = 0; g < NWAIT; g++) begin : g_wait
        swm_down_timer #(.W(TMO_W)) i_tmo (
            .clk(clk), .rst_n(rst_n), .load_i(w_load[g]), .val_i(timeout_i),
            .run_i(w_run[g]), .zero_o(w_zero[g])
        );
    end

    assign ph_run   = (state_q == ST_PRE) || (state_q == ST_REQ) || (state_q == ST_POST);
    assign w_run[0] = (state_q == ST_WFALL);
    assign w_run[1] = (state_q == ST_WRISE);

    // Next-state, timer loads and completion decode.
    always_comb begin
        state_d  = state_q;
        ph_load  = 1'b0;
        ph_val   = HI_LOAD;
        w_load   = '0;
        cap_fall = 1'b0;
        fin_ok   = 1'b0;
        fin_tmo  = 1'b0;
        case (state_q)
            ST_IDLE: if (start_i) begin
                state_d = ST_PRE;
                ph_load = 1'b1;
            end
            ST_PRE: if (ph_zero) begin
                state_d = ST_REQ;
                ph_load = 1'b1;
                ph_val  = req_m1;
            end
            ST_REQ: if (ph_zero) begin
                state_d = ST_POST;
                ph_load = 1'b1;
            end
            ST_POST: if (ph_zero) begin
                state_d   = ST_WFALL;
                w_load[0] = 1'b1;
            end
            ST_WFALL: if (fall_i) begin
                state_d   = ST_WRISE;
                w_load[1] = 1'b1;
                cap_fall  = 1'b1;
            end else if (w_zero[0]) begin
                state_d = ST_IDLE;
                fin_tmo = 1'b1;
            end
            ST_WRISE: if (rise_i) begin
                state_d = ST_IDLE;
                fin_ok  = 1'b1;
            end else if (w_zero[1]) begin
                state_d = ST_IDLE;
                fin_tmo = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the stamp at the falling edge of the reply.
    always_ff @(posedge clk) begin
        if (!rst_n)        t_fall_q <= '0;
        else if (cap_fall) t_fall_q <= stamp_i;
    end

    // Form the result and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= fin_ok | fin_tmo;
            if (fin_ok)       width_q <= stamp_i - t_fall_q;
            else if (fin_tmo) width_q <= '0;
        end
    end

    assign line_oe_o  = ph_run;
    assign line_out_o = (state_q != ST_REQ);
    assign width_o    = width_q;
    assign done_o     = done_q;

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    a_r5_width_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(width_q));

    // R6 and R7: an expired wait ends with a zero result.
    a_r7_timeout_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fin_tmo |=> (done_q && width_q == '0));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> (state_q != ST_IDLE || done_q));
endmodule

// File: rtl/sync_width_meter.sv
// Top of the sync pulse width meter: request driver, synchronised edge
// capture against a free-running stamp, and timeout handling.
// Assumes: line has an external pull-up, so it reads high when released.
module sync_width_meter #(
    parameter int CNT_W    = 16,
    parameter int LEN_W    = 16,
    parameter int TMO_W    = 16,
    parameter int HIGH_CYC = 4,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic [TMO_W-1:0] timeout_i,
    input  logic             line_in_i,
    output logic             line_oe_o,
    output logic             line_out_o,
    output logic [CNT_W-1:0] width_o,
    output logic             done_o
);
    logic             fall, rise;
    logic [CNT_W-1:0] stamp;

    swm_edge_sync #(.STAGES(SYNC_STG)) i_sync (
        .clk(clk), .rst_n(rst_n), .line_i(line_in_i),
        .fall_o(fall), .rise_o(rise)
    );

    swm_stamp #(.W(CNT_W)) i_stamp (
        .clk(clk), .rst_n(rst_n), .stamp_o(stamp)
    );

    swm_seq #(
        .CNT_W(CNT_W), .LEN_W(LEN_W), .TMO_W(TMO_W), .HIGH_CYC(HIGH_CYC)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_len_i(req_len_i),
        .timeout_i(timeout_i), .fall_i(fall), .rise_i(rise), .stamp_i(stamp),
        .line_oe_o(line_oe_o), .line_out_o(line_out_o),
        .width_o(width_o), .done_o(done_o)
    );

    a_r2_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe_o) |-> $past(line_out_o));
endmodule

// File: tb/test_sync_width_meter.sv
module test_sync_width_meter;
    localparam int HI = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] req_len = 16'd10;
    logic [15:0] tmo = 16'd100;
    logic        tgt_low = 1'b0;
    wire         line_oe, line_out, line, done;
    wire  [15:0] width;

    int cyc = 0, ndone = 0, checks = 0, errors = 0, seed_val = 0;

    // Bus model: host drives when enabled, otherwise target or pull-up.
    assign line = line_oe ? line_out : ~tgt_low;

    always #4 clk = ~clk;

    sync_width_meter #(.HIGH_CYC(HI)) i_sync_width_meter (
        .clk(clk), .rst_n(rst_n), .start_i(start), .req_len_i(req_len),
        .timeout_i(tmo), .line_in_i(line), .line_oe_o(line_oe),
        .line_out_o(line_out), .width_o(width), .done_o(done)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rst_n && done) ndone++;

    always @(posedge clk) if (cyc > 190000) begin
        errors++;
        $display("FAIL watchdog: all requirements, actual %0d cycles expected below 190000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected result from the requirements; margins keep cases clear-cut.
    function automatic int expect_width(int pre, int low, int tm);
        if (pre + 8 > tm) return 0;
        if (low + 8 > tm) return 0;
        return low % 65536;
    endfunction

    // kind 0: good reply, 1: no falling edge in time, 2: rising edge too late.
    task automatic measure(int rl, int tm, int pre, int low, bit poke, int kind);
        int n_pre = 0, n_low = 0, n_post = 0, ph = 0;
        int rel_cyc = 0, done_cyc = 0, tgt_end = 0, w = 0, d0 = 0, k = 0;
        int exp_rl = (rl == 0) ? 1 : rl;
        int exp_w = expect_width(pre, low, tm);
        d0 = ndone;
        @(negedge clk);
        req_len = rl[15:0]; tmo = tm[15:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (line_oe) begin
            if (line_out && ph == 0) n_pre++;
            else if (!line_out) begin ph = 1; n_low++; end
            else begin ph = 2; n_post++; end
            @(negedge clk);
        end
        rel_cyc = cyc;
        check("R2 high cycles before request", n_pre, HI);
        check("R3 low request cycles", n_low, exp_rl);
        check("R2 high cycles after request", n_post, HI);
        fork
            begin
                if (poke) begin
                    @(negedge clk); start = 1'b1; req_len = 16'd5;
                    @(negedge clk); start = 1'b0;
                    check("R8 line stays released after ignored start", int'(line_oe), 0);
                    repeat (pre - 2) @(negedge clk);
                end else begin
                    repeat (pre) @(negedge clk);
                end
                tgt_low = 1'b1;
                repeat (low) @(negedge clk);
                tgt_low = 1'b0;
                tgt_end = cyc;
            end
            begin
                k = 0;
                while (!done && k < 70000) begin @(negedge clk); k++; end
                done_cyc = cyc;
                w = int'(width);
            end
        join
        repeat (4) @(negedge clk);
        if (kind == 0) begin
            check("R4 measured width", w, exp_w);
            check("R5 done latency after line high", done_cyc - tgt_end, 3);
        end else if (kind == 1) begin
            check("R6 zero on missing falling edge", w, 0);
            check("R6 timeout latency from release", done_cyc - rel_cyc, tm + 1);
        end else begin
            check("R7 zero on late rising edge", w, 0);
        end
        check("R5 exactly one done pulse (R8)", ndone - d0, 1);
        check("R5 result held after done", int'(width), w);
    endtask

    initial begin
        seed_val = int'($urandom(32'h5eed_0042));
        repeat (5) @(negedge clk);
        check("R1 reset line released", int'(line_oe), 0);
        check("R1 reset done low", int'(done), 0);
        check("R1 reset width zero", int'(width), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        measure(20, 1000, 16, 128, 1'b0, 0);     // R4 basic
        measure(0, 1000, 16, 128, 1'b0, 0);      // R3 zero length as one
        measure(1, 1000, 8, 64, 1'b0, 0);        // R3 shortest request
        measure(50, 1000, 30, 256, 1'b1, 0);     // R8 start while busy
        measure(30, 200, 1500, 100, 1'b0, 1);    // R6
        measure(30, 300, 16, 1200, 1'b0, 2);     // R7
        measure(40, 50000, 16, 40000, 1'b0, 0);  // R4 long pulse, may wrap stamp

        for (int i = 0; i < 16; i++) begin
            int rl = 1 + int'($urandom % 300);
            int t  = 1 + int'($urandom % 6);
            measure(rl, 4000, 16 * t, 128 * t, 1'b0, 0);  // R4 random rates
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule